// File: doc/BRIEF.md
# Command List Group Parser

This block walks a command list held in memory as 64-bit quadwords and turns it into register writes for a graphics engine. Software programs a quadword-aligned start address and a length, given as the number of quadwords minus one, then pulses `start`. The block fetches one quadword at a time over a request/response read port. It splits each quadword into a low and a high 32-bit word, and it treats the list as a run of groups. Each group starts with a header word.

The header selects a destination register index, a data count, fixed or auto-incrementing destination addressing, and an optional hold until the engine reports idle. Data words leave on a valid/ready write port as (byte address, data) pairs. A group always fills a whole number of quadwords, so the word that completes an odd-sized group is padding and is dropped. When the last programmed quadword has been consumed, the block pulses `done` and returns to idle.

Top module: `cmdlist_parser`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `busy`, `done`, `wr_valid` and `rd_req_valid` are all low.
- R2: After `start`, the block reads quadword addresses B, B+8, B+16 and so on, where B is `list_base` with bits 2..0 cleared. It reads exactly `list_qw_m1`+1 quadwords, including when `list_qw_m1` is 0, and holds each request stable until it is accepted.
- R3: A header word is decoded as follows: bit 31 selects incrementing addressing, bit 30 selects wait-for-idle, bits 29..16 give a register index whose byte address is index*4, and bits 15..0 give LEN, the number of data words.
- R4: When bit 31 is 0, all LEN data words of the group are written to the same byte address, index*4.
- R5: When bit 31 is 1, data word k goes to index*4 + 4*k, and the address wraps modulo 2^16.
- R6: Word order within the list is the low half of a quadword (bits 31..0) and then its high half (bits 63..32). The header takes the low half of the group's first quadword and data word 0 takes the high half. Data words are written in list order.
- R7: When a group's header plus data is an odd number of words, the word that completes the last quadword is dropped, and the next header is taken from the low half of the following quadword.
- R8: A header with LEN 0 causes no write. The upper half of its quadword is dropped.
- R9: For a group with bit 30 set, no data is written until `engine_idle` has been seen high after the header. The check is made once, before the first data word. Groups with bit 30 clear are written whatever `engine_idle` is.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay stable.
- R11: `done` is high for exactly one cycle after the last quadword has been consumed, and on the next cycle `busy` is low. `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Launch pulse, accepted only when idle |
| list_base | input | ADDR_W | List start byte address (bits 2..0 ignored) |
| list_qw_m1 | input | CNT_W | List length in quadwords minus one |
| engine_idle | input | 1 | Engine reports it is idle |
| rd_req_valid | output | 1 | Quadword read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Byte address of the requested quadword |
| rd_rsp_valid | input | 1 | Read data returned for the outstanding request |
| rd_rsp_data | input | 64 | Returned quadword |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Engine accepts the write |
| wr_addr | output | 16 | Destination register byte address |
| wr_data | output | 32 | Data word to write |
| busy | output | 1 | A list is being processed |
| done | output | 1 | One-cycle pulse at end of list |

## Verification
A wrong slot pointer or group flag inside the parser shows at the write port. Either a header or a pad word appears as data, or a data word goes missing. The scoreboard flags this at the first misplaced write, normally within a quadword of the fault. A wrong remaining-count or address register gives a wrong `wr_addr` or an extra or missing write, which is caught at that write or at `done` when the expected queue is not empty. A fetch counter fault shows as an off-sequence read address at the very next request, or as a wrong quadword total when `done` fires.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;
  localparam int DW        = 32;
  localparam int QW        = 2 * DW;
  localparam int LEN_W     = 16;
  localparam int IDX_W     = 14;
  localparam int REG_AW    = IDX_W + 2;
  localparam int INCR_BIT  = 31;
  localparam int HOLD_BIT  = 30;
  localparam int IDX_LSB   = 16;

  typedef struct packed {
    logic              incr;
    logic              wait_idle;
    logic [IDX_W-1:0]  idx;
    logic [LEN_W-1:0]  len;
  } grp_hdr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SLOT,
    ST_HOLD,
    ST_EMIT,
    ST_FINISH
  } parse_st_t;
endpackage

// File: rtl/cmdlist_hdr_decode.sv
module cmdlist_hdr_decode
  import cmdlist_pkg::*;
(
  input  logic [DW-1:0] word,
  output grp_hdr_t      hdr
);
  always_comb begin
    hdr.incr      = word[INCR_BIT];
    hdr.wait_idle = word[HOLD_BIT];
    hdr.idx       = word[IDX_LSB +: IDX_W];
    hdr.len       = word[LEN_W-1:0];
  end
endmodule

// File: rtl/cmdlist_fetch.sv
module cmdlist_fetch
  import cmdlist_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              advance,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  qw_m1,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [QW-1:0]     rd_rsp_data,
  output logic [QW-1:0]     qw_data,
  output logic              qw_loaded,
  output logic              qw_last
);
  localparam logic [ADDR_W-1:0] QW_BYTES = ADDR_W'(QW / 8);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(QW_BYTES - ADDR_W'(1));

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, lim_q, lim_d;
  logic              req_q, req_d, pend_q, pend_d;
  logic [QW-1:0]     data_q;
  logic              pos_en, data_en;

  assign pos_en  = launch | advance;
  assign data_en = pend_q & rd_rsp_valid;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    lim_d  = lim_q;
    req_d  = req_q;
    pend_d = pend_q;
    if (launch) begin
      addr_d = base & ALIGN_MASK;
      cnt_d  = '0;
      lim_d  = qw_m1;
    end else if (advance) begin
      addr_d = addr_q + QW_BYTES;
      cnt_d  = cnt_q + CNT_W'(1);
    end
    if (req_q && rd_req_ready) begin
      req_d  = 1'b0;
      pend_d = 1'b1;
    end
    if (data_en) pend_d = 1'b0;
    if (pos_en) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else if (pos_en) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= rd_rsp_data;
  end

  assign rd_req_valid = req_q;
  assign rd_req_addr  = addr_q;
  assign qw_data      = data_q;
  assign qw_loaded    = data_en;
  assign qw_last      = (cnt_q == lim_q);
endmodule

// File: rtl/cmdlist_emit.sv
module cmdlist_emit
  import cmdlist_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  grp_hdr_t          hdr,
  input  logic              step,
  output logic [REG_AW-1:0] addr,
  output logic              rem_one
);
  localparam logic [REG_AW-1:0] STRIDE = REG_AW'(DW / 8);

  logic [REG_AW-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              incr_q, incr_d;
  logic              en;

  assign en = load | step;

  always_comb begin
    addr_d = addr_q;
    rem_d  = rem_q;
    incr_d = incr_q;
    if (load) begin
      addr_d = {hdr.idx, 2'b00};
      rem_d  = hdr.len;
      incr_d = hdr.incr;
    end else if (step) begin
      rem_d = rem_q - LEN_W'(1);
      if (incr_q) addr_d = addr_q + STRIDE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      incr_q <= 1'b0;
    end else if (en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
      incr_q <= incr_d;
    end
  end

  assign addr    = addr_q;
  assign rem_one = (rem_q == LEN_W'(1));
endmodule

// File: rtl/cmdlist_parser.sv
module cmdlist_parser
  import cmdlist_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] list_base,
  input  logic [CNT_W-1:0]  list_qw_m1,
  input  logic              engine_idle,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [63:0]       rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [15:0]       wr_addr,
  output logic [31:0]       wr_data,
  output logic              busy,
  output logic              done
);
  parse_st_t         st_q, st_d;
  logic              slot_q, slot_d;
  logic              in_grp_q, in_grp_d;
  logic              hold_q, hold_d;
  logic [QW-1:0]     qw;
  logic              qw_loaded, qw_last;
  logic              launch, fetch_go, end_qw;
  logic              hdr_load, emit_step, rem_one;
  logic [DW-1:0]     cur_word;
  logic [REG_AW-1:0] emit_addr;
  grp_hdr_t          hdr;

  assign launch   = (st_q == ST_IDLE) && start;
  assign cur_word = slot_q ? qw[QW-1:DW] : qw[DW-1:0];

  cmdlist_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .advance      (fetch_go),
    .base         (list_base),
    .qw_m1        (list_qw_m1),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .qw_data      (qw),
    .qw_loaded    (qw_loaded),
    .qw_last      (qw_last)
  );

  cmdlist_hdr_decode u_dec (
    .word (cur_word),
    .hdr  (hdr)
  );

  cmdlist_emit u_emit (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (hdr_load),
    .hdr     (hdr),
    .step    (emit_step),
    .addr    (emit_addr),
    .rem_one (rem_one)
  );

  always_comb begin
    st_d      = st_q;
    slot_d    = slot_q;
    in_grp_d  = in_grp_q;
    hold_d    = hold_q;
    hdr_load  = 1'b0;
    emit_step = 1'b0;
    end_qw    = 1'b0;
    fetch_go  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d     = ST_FETCH;
          slot_d   = 1'b0;
          in_grp_d = 1'b0;
          hold_d   = 1'b0;
        end
      end
      ST_FETCH: begin
        if (qw_loaded) begin
          st_d   = ST_SLOT;
          slot_d = 1'b0;
        end
      end
      ST_SLOT: begin
        if (in_grp_q) begin
          st_d = hold_q ? ST_HOLD : ST_EMIT;
        end else if (!slot_q) begin
          hdr_load = 1'b1;
          if (hdr.len == '0) begin
            end_qw = 1'b1;
          end else begin
            in_grp_d = 1'b1;
            slot_d   = 1'b1;
            hold_d   = hdr.wait_idle;
          end
        end else begin
          end_qw = 1'b1;
        end
      end
      ST_HOLD: begin
        if (engine_idle) begin
          hold_d = 1'b0;
          st_d   = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (wr_ready) begin
          emit_step = 1'b1;
          if (rem_one) in_grp_d = 1'b0;
          if (!slot_q) begin
            slot_d = 1'b1;
            st_d   = ST_SLOT;
          end else begin
            end_qw = 1'b1;
          end
        end
      end
      ST_FINISH: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
    if (end_qw) begin
      if (qw_last) begin
        st_d = ST_FINISH;
      end else begin
        fetch_go = 1'b1;
        st_d     = ST_FETCH;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      slot_q   <= 1'b0;
      in_grp_q <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      slot_q   <= slot_d;
      in_grp_q <= in_grp_d;
      hold_q   <= hold_d;
    end
  end

  assign wr_valid = (st_q == ST_EMIT);
  assign wr_addr  = emit_addr;
  assign wr_data  = cur_word;
  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_FINISH);
endmodule

// File: rtl/cmdlist_parser_chk.sv
module cmdlist_parser_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              engine_idle,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [15:0]       wr_addr,
  input logic [31:0]       wr_data,
  input logic              busy,
  input logic              done,
  input logic              hold
);
  assert_req_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr[2:0] == 3'b000));

  assert_req_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  assert_wr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_hold_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !engine_idle) |=> !wr_valid);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_write_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (busy && !done));

  assert_one_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rd_req_valid);
endmodule

bind cmdlist_parser cmdlist_parser_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .engine_idle  (engine_idle),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .busy         (busy),
  .done         (done),
  .hold         (hold_q)
);

// File: tb/test_cmdlist_parser.sv
module test_cmdlist_parser;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rst_n, start, engine_idle;
  logic [ADDR_W-1:0] list_base;
  logic [CNT_W-1:0]  list_qw_m1;
  logic              rd_req_valid, rd_req_ready, rd_rsp_valid;
  logic [ADDR_W-1:0] rd_req_addr;
  logic [63:0]       rd_rsp_data;
  logic              wr_valid, wr_ready, busy, done;
  logic [15:0]       wr_addr;
  logic [31:0]       wr_data;

  cmdlist_parser #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_cmdlist_parser (
    .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base),
    .list_qw_m1(list_qw_m1), .engine_idle(engine_idle),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  logic [63:0] mem [0:63];
  logic [31:0] dwq[$];
  logic [15:0] exp_a[$];
  logic [31:0] exp_d[$];
  bit          exp_w[$];
  string       exp_t[$];
  int          seq = 0;
  logic [31:0] cur_base = '0;
  int          rd_n = 0;
  int          done_seen = 0;
  int          wr_n = 0;
  bit          idle_flag = 1'b0;
  bit          prev_done = 1'b0;
  bit          stall_wr = 1'b0;
  bit          stall_rd = 1'b0;
  bit          hold_pend = 1'b0;
  logic [15:0] hold_a = '0;
  logic [31:0] hold_d = '0;
  logic [15:0] pa;
  logic [31:0] pd;
  bit          pw;
  string       pt;
  int          cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic void add_group(input bit incr, input bit wt,
                                    input logic [13:0] idx, input int len,
                                    input string tag);
    logic [31:0] h;
    h = {incr, wt, idx, 16'(len)};
    dwq.push_back(h);
    for (int k = 0; k < len; k++) begin
      logic [31:0] d;
      seq++;
      d = 32'h5A00_0000 ^ (32'(seq) * 32'h0001_0103);
      dwq.push_back(d);
      exp_a.push_back({idx, 2'b00} + (incr ? 16'(4 * k) : 16'h0000));
      exp_d.push_back(d);
      exp_w.push_back(wt && (k == 0));
      exp_t.push_back(tag);
    end
    if ((len % 2) == 0) dwq.push_back(32'hBAD0_0000 | 32'(seq));
  endfunction

  function automatic int pack_list();
    int n;
    n = dwq.size() / 2;
    for (int i = 0; i < n; i++) mem[i] = {dwq[2*i+1], dwq[2*i]};
    dwq.delete();
    return n;
  endfunction

  task automatic run_list(input logic [31:0] base, input int nqw, input bit poke);
    int d0;
    d0 = done_seen;
    cur_base = base & ~32'h7;
    rd_n = 0;
    @(posedge clk); #1;
    list_base  = base;
    list_qw_m1 = CNT_W'(nqw - 1);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      repeat (6) @(posedge clk);
      #1;
      list_base  = 32'h0000_7000;
      list_qw_m1 = CNT_W'(3);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (done_seen == d0) @(negedge clk);
    @(negedge clk);
    chk(rd_n == nqw, "R2", "quadwords fetched", 64'(rd_n), 64'(nqw));
    chk(exp_a.size() == 0, "R7", "writes left unissued", 64'(exp_a.size()), 64'd0);
  endtask

  // input drivers for handshake readiness, moved just after each edge
  initial begin
    wr_ready = 1'b1;
    rd_req_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      cyc++;
      wr_ready     = stall_wr ? ((cyc % 3) != 1) : 1'b1;
      rd_req_ready = stall_rd ? ((cyc % 4) != 2) : 1'b1;
    end
  end

  // memory responder, checks each read address (R2)
  initial begin
    rd_rsp_valid = 1'b0;
    rd_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && rd_req_valid && rd_req_ready) begin
        chk(rd_req_addr == cur_base + 32'(8 * rd_n), "R2", "read address",
            64'(rd_req_addr), 64'(cur_base + 32'(8 * rd_n)));
        @(posedge clk); #1;
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem[rd_n % 64];
        rd_n++;
        @(posedge clk); #1;
        rd_rsp_valid = 1'b0;
      end
    end
  end

  // monitor and scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        chk(wr_valid && wr_addr == hold_a && wr_data == hold_d, "R10",
            "stalled write changed", {15'd0, wr_valid, wr_addr, wr_data},
            {15'd0, 1'b1, hold_a, hold_d});
      hold_pend = wr_valid && !wr_ready;
      hold_a = wr_addr;
      hold_d = wr_data;
      if (prev_done) chk(!busy && !done, "R11", "state after done",
                         {62'd0, busy, done}, 64'd0);
      if (done) done_seen++;
      prev_done = done;
      if (wr_valid && wr_ready) begin
        wr_n++;
        if (exp_a.size() == 0) begin
          chk(1'b0, "R8", "unexpected write", {16'd0, wr_addr, wr_data}, 64'd0);
        end else begin
          pa = exp_a.pop_front();
          pd = exp_d.pop_front();
          pw = exp_w.pop_front();
          pt = exp_t.pop_front();
          chk(wr_addr == pa && wr_data == pd, pt, "write",
              {16'd0, wr_addr, wr_data}, {16'd0, pa, pd});
          if (pw) chk(idle_flag, "R9", "write before idle seen", 64'd0, 64'd1);
        end
        idle_flag = 1'b0;
      end
      if (engine_idle) idle_flag = 1'b1;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R11 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int w0;
    rst_n = 1'b0;
    start = 1'b0;
    engine_idle = 1'b1;
    list_base = '0;
    list_qw_m1 = '0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !wr_valid && !rd_req_valid, "R1", "outputs in reset",
        {60'd0, busy, done, wr_valid, rd_req_valid}, 64'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !wr_valid && !rd_req_valid, "R1", "outputs after reset",
        {60'd0, busy, done, wr_valid, rd_req_valid}, 64'd0);

    // fixed, wrapping incremental, empty group, start poked while busy
    add_group(1'b0, 1'b0, 14'h0040, 3, "R4");
    add_group(1'b1, 1'b0, 14'h3FFF, 2, "R5");
    add_group(1'b0, 1'b0, 14'h0123, 0, "R8");
    add_group(1'b1, 1'b0, 14'h0200, 1, "R6");
    n = pack_list();
    run_list(32'h0000_0105, n, 1'b1);

    // wait-for-idle group followed by a plain group with the engine busy
    engine_idle = 1'b0;
    add_group(1'b1, 1'b1, 14'h0100, 4, "R9");
    add_group(1'b0, 1'b0, 14'h0020, 5, "R4");
    n = pack_list();
    w0 = wr_n;
    fork
      run_list(32'h0000_0800, n, 1'b0);
      begin
        repeat (40) @(negedge clk);
        chk(wr_n == w0, "R9", "writes while engine busy", 64'(wr_n - w0), 64'd0);
        @(posedge clk); #1;
        engine_idle = 1'b1;
        while (wr_n == w0) @(negedge clk);
        @(posedge clk); #1;
        engine_idle = 1'b0;
      end
    join

    // back-pressure on both ports, odd group then empty trailing header
    stall_wr = 1'b1;
    stall_rd = 1'b1;
    add_group(1'b1, 1'b0, 14'h2AAA, 3, "R3");
    add_group(1'b0, 1'b0, 14'h0011, 6, "R6");
    add_group(1'b1, 1'b0, 14'h0007, 0, "R8");
    n = pack_list();
    run_list(32'h0000_1FF8, n, 1'b0);

    // single-quadword list
    stall_wr = 1'b0;
    stall_rd = 1'b0;
    engine_idle = 1'b1;
    add_group(1'b0, 1'b0, 14'h0001, 1, "R2");
    n = pack_list();
    run_list(32'h0000_0000, n, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule